// File: doc/BRIEF.md
# Clause 22 Management Master with Programmable Output Hold

This block runs management transactions toward an Ethernet PHY over a two-wire serial bus made of a clock line (MDC) and a bidirectional data line (MDIO). The clock line comes from the system clock through a programmable divider. The data line is modelled as three separate signals: an output value, an output enable and an input. A single configuration word sets the divider and the hold delay. A simple command port starts one read or one write frame at a time and returns the read value together with a one-cycle completion pulse.

The block exists for fast system clocks. With a plain registered output, the data line changes one system clock after the MDC falling edge, which is shorter than the required 10 ns hold at clock rates above 100 MHz. Here every change of the MDIO output and its enable is held back after the falling edge by a programmed number of system clocks. Software sets the hold field to ceil(f_clk / 100 MHz) − 1. It sets the divider field to ceil(f_clk / 5 MHz) − 1, which keeps MDC at or below 2.5 MHz.

The controller is a four-state machine:
- ST_IDLE holds MDC low and the data line released.
- ST_LOW is the low half of an MDC period.
- ST_HIGH is the high half of an MDC period.
- ST_TAIL waits out the hold delay after the last falling edge.

It has these transitions:
- IDLE→LOW when a start is accepted.
- LOW→HIGH at the rising edge.
- HIGH→LOW at a falling edge that opens the next bit.
- HIGH→TAIL at the falling edge that ends the last bit.
- TAIL→IDLE when the hold delay runs out.

Top module: `mdio_hold_master`

## Requirements
- R1: The divider field D is cfg_word[6:1] and the hold field H is cfg_word[10:8]. Every other bit of cfg_word has no effect on any output.
- R2: After an accepted start, MDC stays low for D+1 system clocks and then high for D+1 system clocks, for each of 64 bit slots. MDC is low whenever the block is not busy.
- R3: With D = 0, a start is ignored: busy stays low and MDC stays low.
- R4: Each frame carries these 64 bits, in slot order:
  - 32 ones;
  - start bits 0 then 1;
  - an opcode, 1,0 for a read (rd_nwr=1) and 0,1 for a write;
  - phy_addr, most significant bit first;
  - reg_addr, most significant bit first;
  - two turnaround bits;
  - 16 data bits, most significant bit first.
- R5: On a write, mdio_oe is high for all 64 slots, the turnaround is driven as 1 then 0, and the data slots carry wr_data.
- R6: On a read, mdio_oe is low (with mdio_o at 1) from the first turnaround slot to the end of the frame. mdio_i is sampled at the MDC rising edge of each of the 16 data slots, and the samples form rd_data, most significant bit first.
- R7: The slot-k value of mdio_o and mdio_oe appears E system clocks after the falling edge that opens slot k, where E = min(H+1, D). Slot 0 has no such falling edge; its value appears E clocks after the clock edge that accepts the start. Neither signal ever changes in the cycle in which MDC falls.
- R8: E clocks after the last falling edge, the following happen in the same cycle: done pulses for exactly one system clock, busy drops, mdio_oe goes low and mdio_o goes to 1. rd_data holds the read result from that cycle until the next start is accepted.
- R9: A start asserted while busy is high is ignored, and the frame in progress is unchanged.
- R10: cfg_word and the command inputs are sampled only when a start is accepted. Changing them during a frame does not affect that frame.
- R11: After reset, mdc=0, mdio_oe=0, mdio_o=1, done=0, busy=0 and rd_data=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Configuration word: divider in bits 6:1, hold in bits 10:8 |
| start | input | 1 | Request one frame; accepted only when idle and D is not 0 |
| rd_nwr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Data for a write frame |
| rd_data | output | 16 | Data captured during a read frame |
| done | output | 1 | One-cycle pulse at the end of a frame |
| busy | output | 1 | High while a frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest situation to reach is the clamp of the hold delay. This happens when H+1 is larger than the MDC half period, so E is set by the divider and not by the hold field. The bench reaches it with a frame that uses D=3 and H=7, and it places a second start and a new configuration word in the middle of that same frame. A behavioural model checks every cycle of that frame. It shows that neither the clamped launch point nor the frame contents move. Read frames get their data from a bench PHY that changes mdio_i only around the computed rising-edge sample points. Divider values of 1 and 63 cover the shortest and the longest MDC period.

// File: rtl/mdio_hold_pkg.sv
package mdio_hold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } mdio_state_e;

endpackage

// File: rtl/mdio_cfg_decode.sv
module mdio_cfg_decode #(
    parameter int CFG_W    = 16,
    parameter int DIV_W    = 6,
    parameter int DIV_LSB  = 1,
    parameter int HOLD_W   = 3,
    parameter int HOLD_LSB = 8,
    localparam int HCNT_W  = HOLD_W + 1
) (
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [DIV_W-1:0]  div_val,
    output logic [HCNT_W-1:0] hold_eff,
    output logic              div_ok
);
    localparam int CMP_W = DIV_W + HCNT_W;

    logic [HOLD_W-1:0] hold_raw;
    logic [HCNT_W-1:0] hold_p1;

    always_comb begin
        div_val  = cfg_word[DIV_LSB +: DIV_W];
        hold_raw = cfg_word[HOLD_LSB +: HOLD_W];
        div_ok   = (div_val != '0);
        hold_p1  = HCNT_W'(hold_raw) + HCNT_W'(1);
        // never let the launch point reach the rising edge of MDC
        if (CMP_W'(hold_p1) > CMP_W'(div_val)) begin
            hold_eff = HCNT_W'(div_val);
        end else begin
            hold_eff = hold_p1;
        end
    end

endmodule

// File: rtl/mdio_hold_delay.sv
module mdio_hold_delay #(
    parameter int HCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HCNT_W-1:0] load_val,
    output logic              launch
);
    logic [HCNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - HCNT_W'(1);
        end
    end

    assign launch = (remain == HCNT_W'(1));

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_en,
    input  logic              din,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clear) begin
            data <= '0;
        end else if (sample_en) begin
            data <= {data[DATA_W-2:0], din};
        end
    end

endmodule

// File: rtl/mdio_hold_master.sv
module mdio_hold_master #(
    parameter int CFG_W    = 16,
    parameter int DIV_W    = 6,
    parameter int DIV_LSB  = 1,
    parameter int HOLD_W   = 3,
    parameter int HOLD_LSB = 8,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PRE_N    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    import mdio_hold_pkg::*;

    localparam int HCNT_W  = HOLD_W + 1;
    localparam int ST_POS  = PRE_N;
    localparam int OP_POS  = ST_POS + 2;
    localparam int PA_POS  = OP_POS + 2;
    localparam int RA_POS  = PA_POS + ADDR_W;
    localparam int TA_POS  = RA_POS + ADDR_W;
    localparam int DAT_POS = TA_POS + 2;
    localparam int FRAME_N = DAT_POS + DATA_W;
    localparam int IDX_W   = $clog2(FRAME_N);

    mdio_state_e state_q, state_nx;

    logic [DIV_W-1:0]   div_in;
    logic [HCNT_W-1:0]  eff_in;
    logic               div_ok;
    logic [DIV_W-1:0]   div_q;
    logic [HCNT_W-1:0]  eff_q;
    logic               rd_q;
    logic [DIV_W-1:0]   half_cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [FRAME_N-1:0] frm_d, oe_d, frm_q, oe_q;
    logic               accept, rise_ev, fall_ev, last_bit;
    logic               hold_load, launch, sample_en;
    logic [HCNT_W-1:0]  hold_val;

    mdio_cfg_decode #(
        .CFG_W(CFG_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
        .HOLD_W(HOLD_W), .HOLD_LSB(HOLD_LSB)
    ) u_decode (
        .cfg_word (cfg_word),
        .div_val  (div_in),
        .hold_eff (eff_in),
        .div_ok   (div_ok)
    );

    // frame image: index k is the bit sent in slot k
    always_comb begin
        frm_d = '1;
        oe_d  = '1;
        frm_d[ST_POS]     = 1'b0;
        frm_d[ST_POS + 1] = 1'b1;
        frm_d[OP_POS]     = rd_nwr;
        frm_d[OP_POS + 1] = ~rd_nwr;
        for (int j = 0; j < ADDR_W; j++) begin
            frm_d[PA_POS + j] = phy_addr[ADDR_W-1-j];
            frm_d[RA_POS + j] = reg_addr[ADDR_W-1-j];
        end
        if (rd_nwr) begin
            for (int j = TA_POS; j < FRAME_N; j++) begin
                oe_d[j] = 1'b0;
            end
        end else begin
            frm_d[TA_POS + 1] = 1'b0;
            for (int j = 0; j < DATA_W; j++) begin
                frm_d[DAT_POS + j] = wr_data[DATA_W-1-j];
            end
        end
    end

    assign accept    = (state_q == ST_IDLE) && start && div_ok;
    assign rise_ev   = (state_q == ST_LOW)  && (half_cnt == div_q);
    assign fall_ev   = (state_q == ST_HIGH) && (half_cnt == div_q);
    assign last_bit  = (bit_idx == IDX_W'(FRAME_N - 1));
    assign hold_load = accept || fall_ev;
    assign hold_val  = accept ? eff_in : eff_q;
    assign sample_en = rise_ev && rd_q && (bit_idx >= IDX_W'(DAT_POS));
    assign busy      = (state_q != ST_IDLE);

    mdio_hold_delay #(.HCNT_W(HCNT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_val),
        .launch   (launch)
    );

    mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (sample_en),
        .din       (mdio_i),
        .data      (rd_data)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_nx = ST_LOW;
            ST_LOW:  if (rise_ev) state_nx = ST_HIGH;
            ST_HIGH: if (fall_ev) state_nx = last_bit ? ST_TAIL : ST_LOW;
            ST_TAIL: if (launch)  state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc      <= 1'b0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
            div_q    <= '0;
            eff_q    <= '0;
            rd_q     <= 1'b0;
            half_cnt <= '0;
            bit_idx  <= '0;
            frm_q    <= '0;
            oe_q     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        div_q    <= div_in;
                        eff_q    <= eff_in;
                        rd_q     <= rd_nwr;
                        frm_q    <= frm_d;
                        oe_q     <= oe_d;
                        half_cnt <= '0;
                        bit_idx  <= '0;
                    end
                end
                ST_LOW: begin
                    if (rise_ev) begin
                        mdc      <= 1'b1;
                        half_cnt <= '0;
                    end else begin
                        half_cnt <= half_cnt + DIV_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (fall_ev) begin
                        mdc      <= 1'b0;
                        half_cnt <= '0;
                        if (!last_bit) begin
                            bit_idx <= bit_idx + IDX_W'(1);
                        end
                    end else begin
                        half_cnt <= half_cnt + DIV_W'(1);
                    end
                end
                ST_TAIL: begin
                    half_cnt <= '0;
                end
                default: begin
                    half_cnt <= '0;
                end
            endcase
            if (launch) begin
                if (state_q == ST_TAIL) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    mdio_o  <= frm_q[bit_idx];
                    mdio_oe <= oe_q[bit_idx];
                end
            end
        end
    end

endmodule

// File: rtl/mdio_hold_master_chk.sv
module mdio_hold_master_chk #(
    parameter int CFG_W   = 16,
    parameter int DIV_W   = 6,
    parameter int DIV_LSB = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_word,
    input logic             start,
    input logic             done,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    assert_no_change_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mdio_oe && mdio_o));

    assert_mdc_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_released_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_zero_div_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (cfg_word[DIV_LSB +: DIV_W] == '0)) |=> !busy);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(mdio_o));

endmodule

bind mdio_hold_master mdio_hold_master_chk #(
    .CFG_W(CFG_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .start    (start),
    .done     (done),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_hold_master_bench.sv
module mdio_hold_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        done, busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mdio_hold_master u_mdio_hold_master (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .start(start),
        .rd_nwr(rd_nwr), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .done(done), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_cfg(input int d, input int h);
        // R1: unused bits forced to ones
        return 16'hF881 | 16'((d & 63) << 1) | 16'((h & 7) << 8);
    endfunction

    task automatic run_frame(input int d, input int h, input bit rd,
                             input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] pd,
                             input bit disturb);
        bit exp_bit[$];
        bit exp_en[$];
        int half, eff, n_end, fails0;
        half = d + 1;
        eff  = (h + 1 < d) ? h + 1 : d;
        n_end = 128 * half + eff;
        // R4 frame contents from the requirement text
        for (int i = 0; i < 32; i++) begin exp_bit.push_back(1); exp_en.push_back(1); end
        exp_bit.push_back(0); exp_en.push_back(1);
        exp_bit.push_back(1); exp_en.push_back(1);
        exp_bit.push_back(rd); exp_en.push_back(1);
        exp_bit.push_back(!rd); exp_en.push_back(1);
        for (int i = 4; i >= 0; i--) begin exp_bit.push_back(pa[i]); exp_en.push_back(1); end
        for (int i = 4; i >= 0; i--) begin exp_bit.push_back(ra[i]); exp_en.push_back(1); end
        if (rd) begin
            for (int i = 0; i < 18; i++) begin exp_bit.push_back(1); exp_en.push_back(0); end
        end else begin
            exp_bit.push_back(1); exp_en.push_back(1);
            exp_bit.push_back(0); exp_en.push_back(1);
            for (int i = 15; i >= 0; i--) begin exp_bit.push_back(wd[i]); exp_en.push_back(1); end
        end
        fails0 = failures;
        @(negedge clk);
        cfg_word = mk_cfg(d, h);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= n_end; n++) begin
            logic e_mdc, e_o, e_oe;
            int k, m, slot;
            e_mdc = (n < 128 * half) ? ((n % (2 * half)) >= half) : 1'b0;
            if (n < eff || n >= n_end) begin
                e_o = 1'b1; e_oe = 1'b0;
            end else begin
                k = (n - eff) / (2 * half);
                if (k > 63) k = 63;
                e_o = exp_bit[k]; e_oe = exp_en[k];
            end
            chk("R1 R2 mdc", 32'(mdc), 32'(e_mdc));
            chk(rd ? "R4 R6 R7 mdio_o" : "R4 R5 R7 mdio_o", 32'(mdio_o), 32'(e_o));
            chk(rd ? "R6 R7 mdio_oe" : "R5 R7 mdio_oe", 32'(mdio_oe), 32'(e_oe));
            chk("R8 done", 32'(done), 32'(n == n_end));
            chk("R8 busy", 32'(busy), 32'(n < n_end));
            if (n == n_end && rd) chk("R6 R8 rd_data", 32'(rd_data), 32'(pd));
            if (disturb && n == 5) begin
                start = 1'b1; rd_nwr = !rd; phy_addr = ~pa; reg_addr = ~ra;
                wr_data = ~wd; cfg_word = mk_cfg(1, 0);
            end
            if (disturb && n == 6) start = 1'b0;
            m = n + 1;
            slot = m / (2 * half);
            mdio_i = (rd && slot >= 48 && slot <= 63) ? pd[15 - (slot - 48)] : 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        if (disturb) chk("R9 R10 disturbed frame unchanged", 32'(failures - fails0), 32'd0);
        mdio_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 mdc", 32'(mdc), 32'd0);
        chk("R11 mdio_oe", 32'(mdio_oe), 32'd0);
        chk("R11 mdio_o", 32'(mdio_o), 32'd1);
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 rd_data", 32'(rd_data), 32'd0);

        // R3 zero divider blocks start
        cfg_word = mk_cfg(0, 2);
        start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R3 busy stays low", 32'(busy), 32'd0);
            chk("R3 mdc stays low", 32'(mdc), 32'd0);
        end
        start = 1'b0;

        run_frame(1, 0, 1'b0, 5'h11, 5'h0A, 16'hBEEF, 16'h0000, 1'b0);
        run_frame(2, 1, 1'b1, 5'h03, 5'h1F, 16'h0000, 16'hA5C3, 1'b0);
        run_frame(3, 7, 1'b0, 5'h1C, 5'h05, 16'h1234, 16'h0000, 1'b1);
        run_frame(5, 2, 1'b1, 5'h00, 5'h12, 16'h0000, 16'h8001, 1'b1);
        run_frame(4, 0, 1'b0, 5'h1F, 5'h00, 16'h0000, 16'h0000, 1'b0);
        run_frame(63, 7, 1'b1, 5'h15, 5'h0E, 16'h0000, 16'h7E5A, 1'b0);

        repeat (4) @(negedge clk);
        chk("R8 idle after frames", 32'({mdc, mdio_oe, busy}), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule